// File: doc/BRIEF.md
# SPI Receive-to-Memory DMA Engine

This block moves data received by an SPI master into system memory without processor involvement. It takes frames from the master's receive FIFO one at a time. Each frame is one byte (8-bit frames) or two bytes (16-bit frames). The engine stores each frame through a memory write port, using a store whose width matches the frame. After each store it advances a destination pointer and lowers a remaining-byte counter by the number of bytes written.

Software sets up a transfer through a small 32-bit register window:

1. Write the destination pointer.
2. Write the byte count.
3. Issue a start strobe.

The start strobe adds one to the count and enables the engine. When the count reaches zero, the engine sets a data-available status flag and stops taking frames. Any frames left in the FIFO stay there. The flag drives a single interrupt line through a mask bit. If a 16-bit frame arrives when only one byte of the transfer is left, only its low byte is written and the rest of the frame is discarded.

Register offsets: 0x00 control, 0x04 destination, 0x08 count, 0x10 status, 0x14 mask. Offsets 0x0C and 0x18 are placeholders that read zero. The decoded window is 256 bytes.

Top module: `spi_rx_dma`

## Requirements
- R1: After reset the control register (0x00) reads 0x40, the mask register (0x14) reads 0x7, and destination, count and status read 0. The outputs irq, fifo_pop and mem_valid are 0.
- R2: Writing 1 to control bit 0 (start) adds 1 to the count, clears the data-available flag and enables the engine. Writing 1 to control bit 1 (stop) disables it. A single write with both bits set adds 1 and leaves the engine disabled.
- R3: While the engine is disabled, fifo_pop stays 0 whatever fifo_valid does, and the count is unchanged.
- R4: An 8-bit frame (fifo_wide=0) is written with mem_size=0 (byte), carrying the frame's low 8 bits on mem_wdata[7:0] with zeros above. On acceptance the count falls by 1 and the destination rises by 1.
- R5: A 16-bit frame (fifo_wide=1), when at least 2 bytes remain, is written with mem_size=1 (halfword) carrying all 16 bits. On acceptance the count falls by 2 and the destination rises by 2.
- R6: A 16-bit frame that arrives with exactly 1 byte remaining is written as a byte store of its low 8 bits, and the count reaches 0.
- R7: When the count reaches 0, status bit 1 (0x10 reads 0x2) is set, and fifo_pop stays 0 while the count is 0.
- R8: irq equals status bit 1 ANDed with mask bit 1. Mask bits [2:0] are writable.
- R9: A frame is popped only when no store is pending. A pending store keeps mem_addr, mem_size and mem_wdata steady until mem_ready. The count and destination update at the clock edge where mem_valid and mem_ready are both 1.
- R10: Register bits with no function read 0 and ignore writes. The count keeps only bits [25:0], and the read-only status register ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| fifo_valid | input | 1 | Receive FIFO holds a frame |
| fifo_wide | input | 1 | Frame size: 0 = 8-bit, 1 = 16-bit |
| fifo_data | input | 16 | Frame at the FIFO head |
| fifo_pop | output | 1 | Removes the head frame at this clock edge |
| mem_valid | output | 1 | Store request pending |
| mem_ready | input | 1 | Memory accepts the store |
| mem_addr | output | 32 | Store byte address |
| mem_size | output | 2 | 0 = byte, 1 = halfword |
| mem_wdata | output | 16 | Store data |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench builds the block with its default widths: a 32-bit destination and a 26-bit count. With the 26-bit count, writing all ones shows that the count keeps only bits [25:0]. A seven-byte transfer mixes byte and halfword frames with different memory stall lengths, so the last frame meets the one-byte clamp. A follow-up phase covers the stop and start strobes, masking, and FIFO data that is ignored.

// File: rtl/spi_rx_dma_pkg.sv
package spi_rx_dma_pkg;
    localparam int REG_AW = 8;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_DST   = 8'h04;
    localparam logic [REG_AW-1:0] OFS_CNT   = 8'h08;
    localparam logic [REG_AW-1:0] OFS_STAT  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_MASK  = 8'h14;
    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_STOP_BIT  = 1;
    localparam int CTRL_RDY_BIT   = 6;
    localparam int DONE_BIT       = 1;
    localparam int MASK_W         = 3;
    localparam logic [MASK_W-1:0] MASK_RST = 3'b111;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1
    } mem_size_e;

    typedef enum logic {
        ENG_IDLE,
        ENG_STORE
    } eng_state_e;
endpackage

// File: rtl/spi_rx_dma_regs.sv
module spi_rx_dma_regs
    import spi_rx_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              consume,
    input  logic [1:0]        consume_bytes,
    output logic              en,
    output logic [CW-1:0]     cnt,
    output logic [AW-1:0]     dst,
    output logic              irq
);
    typedef struct packed {
        logic              en;
        logic [CW-1:0]     cnt;
        logic [AW-1:0]     dst;
        logic              done;
        logic [MASK_W-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, wr_dst, wr_cnt, wr_mask;
    logic [CW-1:0] step;

    always_comb begin
        r_d     = r_q;
        wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
        wr_dst  = reg_we && (reg_addr == OFS_DST);
        wr_cnt  = reg_we && (reg_addr == OFS_CNT);
        wr_mask = reg_we && (reg_addr == OFS_MASK);
        step    = CW'(consume_bytes);

        if (consume) begin
            r_d.dst = r_q.dst + AW'(consume_bytes);
            if (r_q.cnt > step) begin
                r_d.cnt = r_q.cnt - step;
            end else begin
                r_d.cnt  = '0;
                r_d.done = 1'b1;
            end
        end
        if (wr_dst)  r_d.dst  = reg_wdata[AW-1:0];
        if (wr_cnt)  r_d.cnt  = reg_wdata[CW-1:0];
        if (wr_mask) r_d.mask = reg_wdata[MASK_W-1:0];
        if (wr_ctrl) begin
            if (reg_wdata[CTRL_START_BIT]) begin
                r_d.en   = 1'b1;
                r_d.cnt  = r_d.cnt + CW'(1);
                r_d.done = 1'b0;
            end
            if (reg_wdata[CTRL_STOP_BIT]) r_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= MASK_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: reg_rdata[CTRL_RDY_BIT] = 1'b1;
            OFS_DST:  reg_rdata[AW-1:0]       = r_q.dst;
            OFS_CNT:  reg_rdata[CW-1:0]       = r_q.cnt;
            OFS_STAT: reg_rdata[DONE_BIT]     = r_q.done;
            OFS_MASK: reg_rdata[MASK_W-1:0]   = r_q.mask;
            default:  reg_rdata = '0;
        endcase
    end

    assign en  = r_q.en;
    assign cnt = r_q.cnt;
    assign dst = r_q.dst;
    assign irq = r_q.done & r_q.mask[DONE_BIT];
endmodule

// File: rtl/spi_rx_dma_eng.sv
module spi_rx_dma_eng
    import spi_rx_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] dst,
    input  logic          fifo_valid,
    input  logic          fifo_wide,
    input  logic [15:0]   fifo_data,
    output logic          fifo_pop,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [15:0]   mem_wdata,
    output logic          consume,
    output logic [1:0]    consume_bytes
);
    typedef struct packed {
        eng_state_e  state;
        logic        two;
        logic [15:0] data;
    } eng_t;

    eng_t e_d, e_q;
    logic room_two;

    always_comb begin
        e_d      = e_q;
        room_two = (cnt >= CW'(2));
        fifo_pop = (e_q.state == ENG_IDLE) && en && (cnt != '0) && fifo_valid;
        mem_valid = (e_q.state == ENG_STORE);
        consume   = mem_valid && mem_ready;

        if (fifo_pop) begin
            e_d.state = ENG_STORE;
            e_d.two   = fifo_wide && room_two;
            e_d.data  = (fifo_wide && room_two) ? fifo_data : {8'h00, fifo_data[7:0]};
        end
        if (consume) e_d.state = ENG_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q       <= '0;
            e_q.state <= ENG_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    assign mem_addr      = dst;
    assign mem_wdata     = e_q.data;
    assign mem_size      = e_q.two ? SZ_HALF : SZ_BYTE;
    assign consume_bytes = e_q.two ? 2'd2 : 2'd1;
endmodule

// File: rtl/spi_rx_dma.sv
module spi_rx_dma
    import spi_rx_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fifo_valid,
    input  logic              fifo_wide,
    input  logic [15:0]       fifo_data,
    output logic              fifo_pop,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        mem_size,
    output logic [15:0]       mem_wdata,
    output logic              irq
);
    logic          dma_en;
    logic [CW-1:0] dma_cnt;
    logic [AW-1:0] dma_dst;
    logic          consume;
    logic [1:0]    consume_bytes;

    spi_rx_dma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .consume       (consume),
        .consume_bytes (consume_bytes),
        .en            (dma_en),
        .cnt           (dma_cnt),
        .dst           (dma_dst),
        .irq           (irq)
    );

    spi_rx_dma_eng #(.AW(AW), .CW(CW)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (dma_en),
        .cnt           (dma_cnt),
        .dst           (dma_dst),
        .fifo_valid    (fifo_valid),
        .fifo_wide     (fifo_wide),
        .fifo_data     (fifo_data),
        .fifo_pop      (fifo_pop),
        .mem_valid     (mem_valid),
        .mem_ready     (mem_ready),
        .mem_addr      (mem_addr),
        .mem_size      (mem_size),
        .mem_wdata     (mem_wdata),
        .consume       (consume),
        .consume_bytes (consume_bytes)
    );
endmodule

// File: rtl/spi_rx_dma_chk.sv
module spi_rx_dma_chk #(
    parameter int AW = 32,
    parameter int CW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic          fifo_valid,
    input logic          fifo_wide,
    input logic          fifo_pop,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic [15:0]   mem_wdata,
    input logic          dma_en,
    input logic [CW-1:0] dma_cnt
);
    assert_no_pop_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !fifo_pop);

    assert_pop_when_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_valid && !mem_valid));

    assert_store_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && !reg_we) |=>
        (mem_valid && $stable(mem_addr) && $stable(mem_size) && $stable(mem_wdata)));

    assert_no_pop_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_cnt == '0) |-> !fifo_pop);

    assert_clamp_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && fifo_wide && dma_cnt == CW'(1)) |=> (mem_valid && mem_size == 2'd0));

    assert_byte_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_size == 2'd0 && !reg_we) |=>
        (mem_addr == $past(mem_addr) + AW'(1)));

    assert_half_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_size == 2'd1 && !reg_we) |=>
        (mem_addr == $past(mem_addr) + AW'(2)));
endmodule

bind spi_rx_dma spi_rx_dma_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .fifo_valid (fifo_valid),
    .fifo_wide  (fifo_wide),
    .fifo_pop   (fifo_pop),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata),
    .dma_en     (dma_en),
    .dma_cnt    (dma_cnt)
);

// File: tb/sim_spi_rx_dma.sv
module sim_spi_rx_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fifo_valid = 1'b0;
    logic        fifo_wide = 1'b0;
    logic [15:0] fifo_data = '0;
    logic        fifo_pop;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [15:0] mem_wdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_rx_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_valid(fifo_valid),
        .fifo_wide(fifo_wide), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .irq(irq)
    );

    typedef struct packed {
        logic        wide;
        logic [15:0] data;
        logic [3:0]  stall;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [15:0] wdata;
        logic [31:0] cnt_after;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 16'h77A5, 4'd0, 2'd0, 32'h1000, 16'h00A5, 32'd6},
        '{1'b1, 16'h1234, 4'd2, 2'd1, 32'h1001, 16'h1234, 32'd4},
        '{1'b1, 16'hBEEF, 4'd0, 2'd1, 32'h1003, 16'hBEEF, 32'd2},
        '{1'b0, 16'h335A, 4'd1, 2'd0, 32'h1005, 16'h005A, 32'd1},
        '{1'b1, 16'hCAFE, 4'd3, 2'd0, 32'h1006, 16'h00FE, 32'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        bit popped;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 ctrl", v, 32'h40);
        rd(8'h14, v); chk("R1 mask", v, 32'h7);
        rd(8'h04, v); chk("R1 dst", v, 32'h0);
        rd(8'h08, v); chk("R1 cnt", v, 32'h0);
        rd(8'h10, v); chk("R1 stat", v, 32'h0);
        chk("R1 irq/pop/valid", {29'b0, irq, fifo_pop, mem_valid}, 32'h0);

        // R3 disabled: FIFO ignored
        fifo_valid = 1'b1; fifo_data = 16'h1111;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R3 no pop while disabled", {31'b0, fifo_pop}, 32'h0);
        end
        fifo_valid = 1'b0;

        // R2 setup and start
        wr(8'h04, 32'h1000);
        wr(8'h08, 32'd6);
        wr(8'h00, 32'h1);
        rd(8'h08, v); chk("R2 start adds one", v, 32'd7);

        // table walk: R4 R5 R6 R9
        foreach (VECS[k]) begin
            @(negedge clk);
            fifo_valid = 1'b1; fifo_wide = VECS[k].wide; fifo_data = VECS[k].data;
            popped = 0;
            for (int t = 0; t < 10 && !popped; t++) begin
                #1;
                if (fifo_pop) popped = 1;
                else @(negedge clk);
            end
            chk("R9 frame popped", {31'b0, popped}, 32'h1);
            @(negedge clk);
            fifo_valid = 1'b0;
            #1;
            chk("R9 store issued", {31'b0, mem_valid}, 32'h1);
            chk("R4/R5/R6 size", {30'b0, mem_size}, {30'b0, VECS[k].size});
            chk("R4/R5 addr", mem_addr, VECS[k].addr);
            chk("R4/R5/R6 data", {16'b0, mem_wdata}, {16'b0, VECS[k].wdata});
            for (int s = 0; s < int'(VECS[k].stall); s++) begin
                fifo_valid = 1'b1;
                @(negedge clk); #1;
                chk("R9 held while stalled", {mem_valid, fifo_pop, 14'b0, mem_wdata},
                    {1'b1, 1'b0, 14'b0, VECS[k].wdata});
            end
            fifo_valid = 1'b0;
            mem_ready = 1'b1;
            @(negedge clk);
            mem_ready = 1'b0;
            #1;
            chk("R9 store retired", {31'b0, mem_valid}, 32'h0);
            rd(8'h08, v); chk("R4/R5/R6 count", v, VECS[k].cnt_after);
        end
        rd(8'h04, v); chk("R4/R5 final dst", v, 32'h1007);

        // R7 done and parked
        rd(8'h10, v); chk("R7 status set", v, 32'h2);
        chk("R8 irq on", {31'b0, irq}, 32'h1);
        fifo_valid = 1'b1; fifo_data = 16'h4444;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk("R7 no pop at zero", {31'b0, fifo_pop}, 32'h0);
        end
        fifo_valid = 1'b0;

        // R8 mask
        wr(8'h14, 32'h0);
        #1; chk("R8 irq masked", {31'b0, irq}, 32'h0);
        rd(8'h14, v); chk("R8 mask readback", v, 32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v); chk("R10 mask width", v, 32'h7);
        chk("R8 irq unmasked", {31'b0, irq}, 32'h1);

        // R10 status read-only
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R10 status ignores writes", v, 32'h2);

        // R2 start clears status, stop disables
        wr(8'h00, 32'h1);
        rd(8'h10, v); chk("R2 start clears status", v, 32'h0);
        chk("R2 irq cleared", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h2);
        fifo_valid = 1'b1; fifo_wide = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk("R3 stopped no pop", {31'b0, fifo_pop}, 32'h0);
        end
        fifo_valid = 1'b0;
        rd(8'h08, v); chk("R3 count untouched", v, 32'd1);

        wr(8'h00, 32'h3);
        rd(8'h08, v); chk("R2 start+stop count", v, 32'd2);
        fifo_valid = 1'b1;
        @(negedge clk); #1;
        chk("R2 start+stop stays disabled", {31'b0, fifo_pop}, 32'h0);
        fifo_valid = 1'b0;
        rd(8'h00, v); chk("R10 ctrl readback", v, 32'h40);

        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R10 count width", v, 32'h03FF_FFFF);
        rd(8'h0C, v); chk("R10 placeholder 0C", v, 32'h0);
        rd(8'h18, v); chk("R10 placeholder 18", v, 32'h0);

        finish_run();
    end
endmodule